// File: doc/BRIEF.md
# Windowed Round-Robin Way Replacement Picker

This block chooses which way of a highly associative cache set is overwritten when a new line is filled. The ways of every set are divided by three programmable bounds. One window takes ordinary fills and always reaches up to the highest way. A second window takes fills of short-lived data. A way that lies outside both windows is never chosen, so the lines it holds stay pinned in the cache. The two windows may overlap or be disjoint.

Each set keeps its own round-robin pointer for each window. An allocation request is a one-cycle pulse that carries a set index and a flag marking short-lived data. One cycle later the block returns either a way index with a valid strobe, or a no-victim strobe when the selected window is empty. The pointer that was used then steps forward by one, and it wraps from the window's top way back to its bottom way. Writing any bound returns every pointer of the affected window to that window's bottom way. Tag lookup, data storage, bus fills and writeback of evicted lines are handled by other blocks.

Top module: `repl_window_picker`

## Requirements
- R1: For every cycle with `alloc_valid` high, exactly one of `vic_valid` or `vic_none` is high in the next cycle. When `alloc_valid` is low, both are low in the next cycle.
- R2: A request with `alloc_transient` low returns a way in the ordinary window. This window runs from the ordinary bottom bound up to way NUM_WAYS-1.
- R3: A request with `alloc_transient` high returns a way in the short-lived window. This window runs from its bottom bound up to its top bound, both inclusive.
- R4: Successive requests to the same set and window return consecutive ways and wrap from the window's top way to its bottom way. Each set and each window keeps a pointer of its own, and one pointer does not affect another.
- R5: A way that lies outside both windows is never returned with `vic_valid`.
- R6: A write with `cfg_we` high selects a bound through `cfg_sel`: 0 is the ordinary bottom bound, 1 is the short-lived bottom bound, 2 is the short-lived top bound. The write resets every pointer of that window to the window's bottom bound after the write. A write with `cfg_sel` equal to 3 changes nothing.
- R7: When a window's bottom bound is above its top bound, a request for that window produces `vic_none` and leaves its pointer unchanged.
- R8: After reset the ordinary bottom bound is 0, the short-lived window spans ways 0 to NUM_WAYS-1, every pointer is 0, and both strobes are low.
- R9: When a request and a bound write occur in the same cycle, the request is answered with the bounds and pointer from before the write. The pointer reset caused by the write then takes the place of that request's pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_valid | input | 1 | One-cycle allocation request |
| alloc_set | input | SET_W (3) | Set index of the request |
| alloc_transient | input | 1 | Request targets the short-lived window |
| cfg_we | input | 1 | Bound write strobe |
| cfg_sel | input | 2 | Bound select: 0 ordinary bottom, 1 short-lived bottom, 2 short-lived top, 3 unused |
| cfg_wdata | input | WAY_W (6) | New bound value |
| vic_valid | output | 1 | Registered strobe: `vic_way` holds the chosen way |
| vic_none | output | 1 | Registered strobe: the requested window is empty |
| vic_way | output | WAY_W (6) | Chosen way index |

## Verification
The bench builds the block with its default 64 ways and 8 sets, so the full-width pointer wrap at way 63 and the six-bit compare of the bounds are both exercised. With eight sets, random set indices reuse each pointer often enough to cover long round-robin runs per set and window. They also leave sets untouched between bound writes, so pointer independence across sets becomes visible. Random bound writes produce overlapping, disjoint, single-way and empty windows, and they sometimes land in the same cycle as a request.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    SEL_NORM_FLOOR  = 2'd0,
    SEL_TRANS_FLOOR = 2'd1,
    SEL_TRANS_CEIL  = 2'd2,
    SEL_UNUSED      = 2'd3
  } bound_sel_e;
endpackage

// File: rtl/repl_rst_sync.sv
module repl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/repl_bounds.sv
module repl_bounds
  import repl_pkg::*;
#(
  parameter int WAY_W    = 6,
  parameter int TOP_WAY  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [WAY_W-1:0] wdata,
  output logic [WAY_W-1:0] norm_floor,
  output logic [WAY_W-1:0] trans_floor,
  output logic [WAY_W-1:0] trans_ceil,
  output logic             norm_clr,
  output logic             trans_clr,
  output logic [WAY_W-1:0] norm_clr_val,
  output logic [WAY_W-1:0] trans_clr_val
);
  logic [WAY_W-1:0] nf_q, tf_q, tc_q;
  logic             nf_en, tf_en, tc_en;
  bound_sel_e       sel_e;

  always_comb begin
    sel_e         = bound_sel_e'(sel);
    nf_en         = we && (sel_e == SEL_NORM_FLOOR);
    tf_en         = we && (sel_e == SEL_TRANS_FLOOR);
    tc_en         = we && (sel_e == SEL_TRANS_CEIL);
    norm_clr      = nf_en;
    trans_clr     = tf_en || tc_en;
    norm_clr_val  = wdata;
    trans_clr_val = tf_en ? wdata : tf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q <= '0;
      tf_q <= '0;
      tc_q <= WAY_W'(TOP_WAY);
    end else begin
      if (nf_en) nf_q <= wdata;
      if (tf_en) tf_q <= wdata;
      if (tc_en) tc_q <= wdata;
    end
  end

  assign norm_floor  = nf_q;
  assign trans_floor = tf_q;
  assign trans_ceil  = tc_q;
endmodule

// File: rtl/repl_ptr_bank.sv
module repl_ptr_bank #(
  parameter int NUM_SETS = 8,
  parameter int WAY_W    = 6,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_ptr,
  input  logic             adv_en,
  input  logic [WAY_W-1:0] adv_val,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] clr_val
);
  logic [WAY_W-1:0] ptr_q [NUM_SETS];
  logic [WAY_W-1:0] ptr_d [NUM_SETS];
  logic             ptr_en [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_comb begin
      ptr_en[s] = clr_en || (adv_en && (rd_set == SET_W'(s)));
      ptr_d[s]  = clr_en ? clr_val : adv_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptr_q[s] <= '0;
      else if (ptr_en[s]) ptr_q[s] <= ptr_d[s];
    end
  end

  assign rd_ptr = ptr_q[rd_set];
endmodule

// File: rtl/repl_rr_step.sv
module repl_rr_step #(
  parameter int WAY_W = 6
) (
  input  logic [WAY_W-1:0] ptr,
  input  logic [WAY_W-1:0] floor_w,
  input  logic [WAY_W-1:0] ceil_w,
  output logic             empty,
  output logic [WAY_W-1:0] way,
  output logic [WAY_W-1:0] nxt
);
  always_comb begin
    empty = floor_w > ceil_w;
    way   = ((ptr < floor_w) || (ptr > ceil_w)) ? floor_w : ptr;
    nxt   = (way == ceil_w) ? floor_w : way + WAY_W'(1);
  end
endmodule

// File: rtl/repl_window_picker.sv
module repl_window_picker #(
  parameter int NUM_WAYS = 64,
  parameter int NUM_SETS = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [SET_W-1:0] alloc_set,
  input  logic             alloc_transient,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [WAY_W-1:0] cfg_wdata,
  output logic             vic_valid,
  output logic             vic_none,
  output logic [WAY_W-1:0] vic_way
);
  localparam logic [WAY_W-1:0] TOP = WAY_W'(NUM_WAYS - 1);

  logic             rst_n_s;
  logic [WAY_W-1:0] norm_floor, trans_floor, trans_ceil;
  logic             norm_clr, trans_clr;
  logic [WAY_W-1:0] norm_clr_val, trans_clr_val;
  logic [WAY_W-1:0] n_ptr, t_ptr;
  logic             n_empty, t_empty;
  logic [WAY_W-1:0] n_way, t_way, n_nxt, t_nxt;
  logic             n_adv, t_adv;
  logic             sel_empty;
  logic [WAY_W-1:0] sel_way;
  logic             valid_d, none_d;
  logic [WAY_W-1:0] way_d;
  logic             valid_q, none_q;
  logic [WAY_W-1:0] way_q;

  repl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  repl_bounds #(.WAY_W(WAY_W), .TOP_WAY(NUM_WAYS - 1)) u_bounds (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .we            (cfg_we),
    .sel           (cfg_sel),
    .wdata         (cfg_wdata),
    .norm_floor    (norm_floor),
    .trans_floor   (trans_floor),
    .trans_ceil    (trans_ceil),
    .norm_clr      (norm_clr),
    .trans_clr     (trans_clr),
    .norm_clr_val  (norm_clr_val),
    .trans_clr_val (trans_clr_val)
  );

  repl_ptr_bank #(.NUM_SETS(NUM_SETS), .WAY_W(WAY_W)) u_norm_ptrs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_set  (alloc_set),
    .rd_ptr  (n_ptr),
    .adv_en  (n_adv),
    .adv_val (n_nxt),
    .clr_en  (norm_clr),
    .clr_val (norm_clr_val)
  );

  repl_ptr_bank #(.NUM_SETS(NUM_SETS), .WAY_W(WAY_W)) u_trans_ptrs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_set  (alloc_set),
    .rd_ptr  (t_ptr),
    .adv_en  (t_adv),
    .adv_val (t_nxt),
    .clr_en  (trans_clr),
    .clr_val (trans_clr_val)
  );

  repl_rr_step #(.WAY_W(WAY_W)) u_norm_step (
    .ptr     (n_ptr),
    .floor_w (norm_floor),
    .ceil_w  (TOP),
    .empty   (n_empty),
    .way     (n_way),
    .nxt     (n_nxt)
  );

  repl_rr_step #(.WAY_W(WAY_W)) u_trans_step (
    .ptr     (t_ptr),
    .floor_w (trans_floor),
    .ceil_w  (trans_ceil),
    .empty   (t_empty),
    .way     (t_way),
    .nxt     (t_nxt)
  );

  always_comb begin
    n_adv     = alloc_valid && !alloc_transient && !n_empty;
    t_adv     = alloc_valid &&  alloc_transient && !t_empty;
    sel_empty = alloc_transient ? t_empty : n_empty;
    sel_way   = alloc_transient ? t_way   : n_way;
    valid_d   = alloc_valid && !sel_empty;
    none_d    = alloc_valid &&  sel_empty;
    way_d     = sel_empty ? '0 : sel_way;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      none_q  <= 1'b0;
      way_q   <= '0;
    end else begin
      valid_q <= valid_d;
      none_q  <= none_d;
      if (alloc_valid) way_q <= way_d;
    end
  end

  assign vic_valid = valid_q;
  assign vic_none  = none_q;
  assign vic_way   = way_q;
endmodule

// File: rtl/repl_window_picker_chk.sv
module repl_window_picker_chk #(
  parameter int WAY_W = 6,
  parameter int SET_W = 3
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             alloc_valid,
  input logic             alloc_transient,
  input logic             vic_valid,
  input logic             vic_none,
  input logic [WAY_W-1:0] vic_way,
  input logic [WAY_W-1:0] norm_floor,
  input logic [WAY_W-1:0] trans_floor,
  input logic [WAY_W-1:0] trans_ceil
);
  p_one_answer_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    alloc_valid |=> (vic_valid != vic_none));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !alloc_valid |=> (!vic_valid && !vic_none));

  p_norm_window_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alloc_valid && !alloc_transient) |=> (!vic_valid || (vic_way >= $past(norm_floor))));

  p_trans_window_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alloc_valid && alloc_transient) |=>
      (!vic_valid || ((vic_way >= $past(trans_floor)) && (vic_way <= $past(trans_ceil)))));

  p_empty_none_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (alloc_valid && alloc_transient && (trans_floor > trans_ceil)) |=> vic_none);

  p_strobes_excl_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones({vic_valid, vic_none}) <= 1);
endmodule

bind repl_window_picker repl_window_picker_chk #(.WAY_W(WAY_W), .SET_W(SET_W)) u_chk (
  .clk             (clk),
  .rst_n_s         (rst_n_s),
  .alloc_valid     (alloc_valid),
  .alloc_transient (alloc_transient),
  .vic_valid       (vic_valid),
  .vic_none        (vic_none),
  .vic_way         (vic_way),
  .norm_floor      (norm_floor),
  .trans_floor     (trans_floor),
  .trans_ceil      (trans_ceil)
);

// File: tb/repl_window_picker_bench.sv
`timescale 1ns/1ps
module repl_window_picker_bench;
  localparam int NW = 64;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_valid, alloc_transient, cfg_we;
  logic [2:0] alloc_set;
  logic [1:0] cfg_sel;
  logic [5:0] cfg_wdata;
  logic       vic_valid, vic_none;
  logic [5:0] vic_way;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_nf, m_tf, m_tc;
  int m_pn [NS];
  int m_pt [NS];

  always #2.5 clk = ~clk;

  repl_window_picker u_repl_window_picker (
    .clk, .rst_n, .alloc_valid, .alloc_set, .alloc_transient,
    .cfg_we, .cfg_sel, .cfg_wdata, .vic_valid, .vic_none, .vic_way
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampw(input int p, input int f, input int c);
    return (p < f || p > c) ? f : p;
  endfunction

  // Drives one cycle at a falling edge and checks the answer at the next falling edge.
  task automatic step(input bit av, input int s, input bit tr,
                      input bit we, input int sel, input int d, input string tag);
    int f, c, w, nf0, tf0, tc0;
    bit emp;
    bit ev, en;
    nf0 = m_nf; tf0 = m_tf; tc0 = m_tc;
    alloc_valid = av; alloc_set = 3'(s); alloc_transient = tr;
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = 6'(d);
    f = tr ? m_tf : m_nf;
    c = tr ? m_tc : NW - 1;
    emp = f > c;
    w = clampw(tr ? m_pt[s] : m_pn[s], f, c);
    ev = av && !emp;
    en = av && emp;
    if (ev) begin
      if (tr) m_pt[s] = (w == c) ? f : w + 1;
      else    m_pn[s] = (w == c) ? f : w + 1;
    end
    if (we) begin
      if (sel == 0) begin m_nf = d; foreach (m_pn[i]) m_pn[i] = d; end
      if (sel == 1) begin m_tf = d; foreach (m_pt[i]) m_pt[i] = d; end
      if (sel == 2) begin m_tc = d; foreach (m_pt[i]) m_pt[i] = m_tf; end
    end
    @(negedge clk);
    alloc_valid = 1'b0; cfg_we = 1'b0;
    chk({vic_valid, vic_none} == {ev, en}, {tag, " strobes"},
        int'({vic_valid, vic_none}), int'({ev, en}));
    if (ev) chk(vic_way == 6'(w), {tag, " way"}, vic_way, w);
    if (vic_valid) begin
      bit in_n, in_t;
      in_n = vic_way >= nf0;
      in_t = vic_way >= tf0 && vic_way <= tc0;
      chk(in_n || in_t, "R5 locked way returned", vic_way, -1);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0440));
    rst_n = 1'b0;
    alloc_valid = 0; alloc_set = 0; alloc_transient = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    m_nf = 0; m_tf = 0; m_tc = NW - 1;
    foreach (m_pn[i]) begin m_pn[i] = 0; m_pt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!vic_valid && !vic_none, "R8 strobes in reset", int'({vic_valid, vic_none}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!vic_valid && !vic_none, "R8 strobes after reset", int'({vic_valid, vic_none}), 0);

    // R8 reset bounds and R2 / R4 first fills
    step(1, 0, 0, 0, 0, 0, "R8 R2 first normal fill");
    step(1, 0, 0, 0, 0, 0, "R4 normal advance");
    step(1, 0, 0, 0, 0, 0, "R4 normal advance");
    step(1, 1, 0, 0, 0, 0, "R4 set independence");
    step(1, 3, 1, 0, 0, 0, "R8 R3 transient spans all ways");
    step(0, 0, 0, 0, 0, 0, "R1 idle");
    // R6 bound write resets pointers; R4 wrap at the top way
    step(0, 0, 0, 1, 0, 61, "R6 write ordinary floor");
    step(1, 0, 0, 0, 0, 0, "R6 R2 fill after floor write");
    step(1, 0, 0, 0, 0, 0, "R4 step");
    step(1, 0, 0, 0, 0, 0, "R4 reach top way");
    step(1, 0, 0, 0, 0, 0, "R4 wrap to floor");
    step(1, 1, 0, 0, 0, 0, "R6 other set reset");
    // R3 transient window
    step(0, 0, 0, 1, 1, 10, "R6 write transient floor");
    step(0, 0, 0, 1, 2, 12, "R6 write transient ceiling");
    for (int k = 0; k < 4; k++) step(1, 2, 1, 0, 0, 0, "R3 R4 transient cycle");
    // R7 empty window
    step(0, 0, 0, 1, 2, 5, "R6 shrink transient ceiling");
    step(1, 2, 1, 0, 0, 0, "R7 empty window no victim");
    step(1, 2, 1, 0, 0, 0, "R7 empty window repeated");
    step(1, 0, 0, 0, 0, 0, "R7 ordinary unaffected");
    // R6 unused select ignored
    step(0, 0, 0, 1, 3, 0, "R6 unused select write");
    step(1, 0, 0, 0, 0, 0, "R6 unused select has no effect");
    // R9 same-cycle write and request
    step(1, 0, 0, 1, 0, 40, "R9 request with floor write");
    step(1, 0, 0, 0, 0, 0, "R9 reset wins over advance");
    // R5 locked middle ways
    step(0, 0, 0, 1, 0, 50, "R6 floor 50");
    step(0, 0, 0, 1, 1, 4, "R6 tfloor 4");
    step(0, 0, 0, 1, 2, 7, "R6 tceil 7");
    for (int k = 0; k < 300; k++)
      step(1, int'($urandom % NS), ($urandom % 2) == 0, 0, 0, 0, "R5 R4 locked region run");
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      bit we;
      int sel, d;
      we  = ($urandom % 30) == 0;
      sel = int'($urandom % 4);
      d   = int'($urandom % NW);
      step(($urandom % 4) != 0, int'($urandom % NS), ($urandom % 3) == 0,
           we, sel, d, "R4 R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule